// File: doc/BRIEF.md
# Exit-Target Run-Ahead Predictor

This block predicts control flow for code built from blocks that have one entry point and several possible exits. Only one exit leaves any block that has been entered, so the block keeps a single prediction per block: the full address that the taken exit jumps to. No direction bits and no entries for not-taken exits are stored. The predictor acts purely as a target table keyed by block entry address.

A chain engine walks the predictions ahead of fetch without looking at any instruction bytes. Each predicted target becomes the key of the next lookup, and each hit pushes the predicted entry address into a small queue that fetch drains. Because the table sits away from decode, each lookup takes a fixed number of cycles (`LAT`, default 2). The walk halts on a miss. It also pauses while the queue is full.

When the back end finds a wrong or missing prediction, it sends a redirect. A redirect empties the queue and drops any lookup in flight. It can also install or replace the table entry for the block that went wrong, and it restarts the walk at the actual target. A redirect with the update flag clear only restarts the walk, and this is how the walk is first started.

Top module: `exitpred_top`

## Requirements
- R1: After reset the queue is empty (`q_valid` low) and every table entry is invalid, so a walk started at any address produces no output.
- R2: In the cycle after a redirect is sampled, `q_valid` is low. No address queued or looked up before the redirect ever appears at `q_addr` afterwards.
- R3: A redirect with `redir_update` high writes the entry selected by `redir_block`: index = bits [7:2], tag = bits [15:8], target = `redir_target`. A redirect with `redir_update` low writes nothing.
- R4: After a redirect sampled at clock edge k, the first predicted address appears at `q_addr` with `q_valid` high right after edge k+LAT+1 and not earlier. Its value is the stored target of `redir_target`.
- R5: Each hit target becomes the key of the next lookup, and only one lookup is outstanding at a time. With the queue drained, consecutive predictions enter the queue LAT+1 cycles apart.
- R6: A lookup whose entry is invalid, or whose stored tag differs from bits [15:8] of the key, is a miss. A miss enqueues nothing and halts the walk until the next redirect.
- R7: Writing a key that shares its index with an existing entry replaces that entry's tag and target.
- R8: Address bits above bit 15 and bits [1:0] take no part in indexing or tag compare.
- R9: The queue holds at most DEPTH (4) addresses in FIFO order. While it is full the walk stalls, and no prediction is lost or duplicated.
- R10: The head is removed only on a clock edge where `q_valid` and `q_ready` are both high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Redirect: flush queue and restart the walk |
| redir_update | input | 1 | With a redirect, also write the table entry |
| redir_block | input | 32 | Entry address of the block whose exit resolved |
| redir_target | input | 32 | Actual exit target; restart point of the walk |
| q_valid | output | 1 | Queue head holds a predicted entry address |
| q_ready | input | 1 | Fetch takes the head this cycle |
| q_addr | output | 32 | Predicted entry address at the queue head |

## Verification
Counting from the clock edge that samples a redirect, the queue reads empty after that edge. It stays empty through edge k+LAT, and the first prediction shows after edge k+LAT+1. A popped head is replaced LAT+1 edges after the previous push. The bench drives and samples only on falling edges and counts those edges from the redirect, so it checks emptiness exactly in the LAT cycles it must hold and checks the first and second targets in the cycle they are due. Longer walks, full-queue stalls and random tables are compared, in order, against a list the bench builds from its own copy of the table. After a miss, a quiet window of several lookup periods confirms that nothing more is enqueued.

// File: rtl/exitpred_pkg.sv
`timescale 1ns/1ps
package exitpred_pkg;
    localparam int ADDR_W      = 32;
    localparam int ALIGN_W     = 2;
    localparam int IDX_W       = 6;
    localparam int TAG_W       = 8;
    localparam int LOOKUP_LAT  = 2;
    localparam int QUEUE_DEPTH = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  vld;
        logic  hit;
        addr_t tgt;
    } look_t;

    typedef struct packed {
        addr_t key;
        logic  active;
        logic  busy;
    } chain_t;
endpackage

// File: rtl/exitpred_table.sv
`timescale 1ns/1ps
module exitpred_table
    import exitpred_pkg::*;
#(
    parameter int IDX_BITS = IDX_W,
    parameter int TAG_BITS = TAG_W,
    parameter int LAT      = LOOKUP_LAT
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  addr_t wr_key,
    input  addr_t wr_tgt,
    input  logic  rd_en,
    input  addr_t rd_key,
    input  logic  kill,
    output look_t res
);
    localparam int ENTRIES = 1 << IDX_BITS;
    localparam int IDX_LO  = ALIGN_W;
    localparam int TAG_LO  = ALIGN_W + IDX_BITS;
    localparam int TAG_HI  = TAG_LO + TAG_BITS - 1;

    logic                ent_vld_q [ENTRIES];
    logic [TAG_BITS-1:0] ent_tag_q [ENTRIES];
    addr_t               ent_tgt_q [ENTRIES];

    logic [IDX_BITS-1:0] wr_idx, rd_idx;
    logic [TAG_BITS-1:0] wr_tag, rd_tag;
    logic                unused_key_bits;

    assign wr_idx = wr_key[TAG_LO-1:IDX_LO];
    assign rd_idx = rd_key[TAG_LO-1:IDX_LO];
    assign wr_tag = wr_key[TAG_HI:TAG_LO];
    assign rd_tag = rd_key[TAG_HI:TAG_LO];
    assign unused_key_bits = ^{wr_key[ADDR_W-1:TAG_HI+1], wr_key[IDX_LO-1:0],
                               rd_key[ADDR_W-1:TAG_HI+1], rd_key[IDX_LO-1:0]};

    // valid bits are reset, tag and target storage is not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) ent_vld_q[e] <= 1'b0;
        end else if (wr_en) begin
            ent_vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_tag_q[wr_idx] <= wr_tag;
            ent_tgt_q[wr_idx] <= wr_tgt;
        end
    end

    // read pipeline of LAT stages models the slow far-from-decode array
    look_t pipe_q [LAT];
    look_t pipe_d [LAT];

    always_comb begin
        pipe_d[0].vld = rd_en && !kill;
        pipe_d[0].hit = ent_vld_q[rd_idx] && (ent_tag_q[rd_idx] == rd_tag);
        pipe_d[0].tgt = ent_tgt_q[rd_idx];
        for (int s = 1; s < LAT; s++) begin
            pipe_d[s] = pipe_q[s-1];
            if (kill) pipe_d[s].vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < LAT; s++) pipe_q[s] <= '0;
        end else begin
            for (int s = 0; s < LAT; s++) pipe_q[s] <= pipe_d[s];
        end
    end

    assign res = pipe_q[LAT-1];
endmodule

// File: rtl/exitpred_queue.sv
`timescale 1ns/1ps
module exitpred_queue
    import exitpred_pkg::*;
#(
    parameter int DEPTH = QUEUE_DEPTH,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  addr_t         push_addr,
    input  logic          pop,
    output logic          valid,
    output addr_t         head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t st_q, st_d;
    addr_t   slot_q [DEPTH];
    logic    do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH)) && !flush;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = bump(st_q.wr);
            if (do_pop)  st_d.rd = bump(st_q.rd);
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) slot_q[st_q.wr] <= push_addr;
    end

    assign valid = (st_q.cnt != '0);
    assign head  = slot_q[st_q.rd];
    assign count = st_q.cnt;
endmodule

// File: rtl/exitpred_top.sv
`timescale 1ns/1ps
module exitpred_top
    import exitpred_pkg::*;
#(
    parameter int IDX_BITS = IDX_W,
    parameter int TAG_BITS = TAG_W,
    parameter int LAT      = LOOKUP_LAT,
    parameter int DEPTH    = QUEUE_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_valid,
    input  logic              redir_update,
    input  logic [ADDR_W-1:0] redir_block,
    input  logic [ADDR_W-1:0] redir_target,
    output logic              q_valid,
    input  logic              q_ready,
    output logic [ADDR_W-1:0] q_addr
);
    localparam int CW = $clog2(DEPTH + 1);

    chain_t        st_q, st_d;
    look_t         res;
    logic          issue;
    logic          push;
    logic [CW-1:0] qcount;

    // one lookup in flight; issue only when the result is sure to fit
    assign issue = st_q.active && !st_q.busy && !redir_valid && (qcount < CW'(DEPTH));
    assign push  = res.vld && res.hit && !redir_valid;

    always_comb begin
        st_d = st_q;
        if (redir_valid) begin
            st_d.key    = redir_target;
            st_d.active = 1'b1;
            st_d.busy   = 1'b0;
        end else begin
            if (issue) st_d.busy = 1'b1;
            if (res.vld) begin
                st_d.busy = 1'b0;
                if (res.hit) st_d.key    = res.tgt;
                else         st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    exitpred_table #(
        .IDX_BITS(IDX_BITS),
        .TAG_BITS(TAG_BITS),
        .LAT     (LAT)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (redir_valid && redir_update),
        .wr_key(redir_block),
        .wr_tgt(redir_target),
        .rd_en (issue),
        .rd_key(st_q.key),
        .kill  (redir_valid),
        .res   (res)
    );

    exitpred_queue #(
        .DEPTH(DEPTH)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (redir_valid),
        .push     (push),
        .push_addr(res.tgt),
        .pop      (q_valid && q_ready),
        .valid    (q_valid),
        .head     (q_addr),
        .count    (qcount)
    );
endmodule

// File: rtl/exitpred_chk.sv
`timescale 1ns/1ps
module exitpred_chk
    import exitpred_pkg::*;
#(
    parameter int LAT   = LOOKUP_LAT,
    parameter int DEPTH = QUEUE_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int SW   = $clog2(LAT + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          redir_valid,
    input logic          q_valid,
    input logic          q_ready,
    input addr_t         q_addr,
    input logic          issue,
    input logic [CW-1:0] qcount
);
    // cycles since the last sampled redirect, saturating at LAT+1
    logic [SW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      since_q <= SW'(LAT + 1);
        else if (redir_valid)            since_q <= '0;
        else if (since_q < SW'(LAT + 1)) since_q <= since_q + 1'b1;
    end

    // R2: flush is visible at once
    p_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !q_valid);

    // R4: nothing reaches the queue before the lookup latency has elapsed
    p_first_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q <= SW'(LAT)) |-> !q_valid);

    // R5: a lookup is never issued in back-to-back cycles
    p_single_lookup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);

    // R9: no lookup starts while the queue is full
    p_stall_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (qcount < CW'(DEPTH)));

    // R9: occupancy bound
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        qcount <= CW'(DEPTH));

    // R10: an untaken head holds still
    p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !q_ready && !redir_valid) |=> (q_valid && $stable(q_addr)));
endmodule

bind exitpred_top exitpred_chk #(
    .LAT  (exitpred_pkg::LOOKUP_LAT),
    .DEPTH(exitpred_pkg::QUEUE_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .redir_valid(redir_valid),
    .q_valid    (q_valid),
    .q_ready    (q_ready),
    .q_addr     (q_addr),
    .issue      (issue),
    .qcount     (qcount)
);

// File: tb/tb_exitpred_top.sv
`timescale 1ns/1ps
module tb_exitpred_top;
    import exitpred_pkg::*;

    localparam int LAT = LOOKUP_LAT;
    localparam int NENT = 1 << IDX_W;

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    logic  redir_valid = 1'b0;
    logic  redir_update = 1'b0;
    addr_t redir_block = '0;
    addr_t redir_target = '0;
    logic  q_ready = 1'b0;
    logic  q_valid;
    addr_t q_addr;

    always #2.5 clk = ~clk;

    exitpred_top dut (
        .clk(clk), .rst_n(rst_n),
        .redir_valid(redir_valid), .redir_update(redir_update),
        .redir_block(redir_block), .redir_target(redir_target),
        .q_valid(q_valid), .q_ready(q_ready), .q_addr(q_addr)
    );

    int errors = 0;
    int checks = 0;

    // bench copy of the table
    bit         m_vld [NENT];
    logic [7:0] m_tag [NENT];
    addr_t      m_tgt [NENT];

    addr_t exp_list [32];
    int    exp_n;
    bit    exp_open;

    task automatic chk(input bit ok, input string req, input addr_t act, input addr_t exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic addr_t mk(input logic [7:0] tag, input logic [5:0] idx);
        return {16'h0, tag, idx, 2'b00};
    endfunction

    function automatic bit m_look(input addr_t a, output addr_t t);
        t = m_tgt[a[7:2]];
        return m_vld[a[7:2]] && (m_tag[a[7:2]] == a[15:8]);
    endfunction

    function automatic void build_chain(input addr_t start, input int limit);
        addr_t k = start;
        addr_t t;
        exp_n = 0;
        exp_open = 1'b1;
        for (int i = 0; i < limit; i++) begin
            if (!m_look(k, t)) begin
                exp_open = 1'b0;
                break;
            end
            exp_list[exp_n] = t;
            exp_n++;
            k = t;
        end
    endfunction

    task automatic redirect(input bit upd, input addr_t blk, input addr_t tgt);
        @(negedge clk);
        redir_valid = 1'b1; redir_update = upd; redir_block = blk; redir_target = tgt;
        if (upd) begin
            m_vld[blk[7:2]] = 1'b1;
            m_tag[blk[7:2]] = blk[15:8];
            m_tgt[blk[7:2]] = tgt;
        end
        @(negedge clk);
        redir_valid = 1'b0; redir_update = 1'b0;
    endtask

    // restart the walk at start and check the first result in its cycle
    task automatic timed_start(input addr_t start, input int limit);
        build_chain(start, limit);
        redirect(1'b0, '0, start);
        chk(!q_valid, "R2 flush", addr_t'(q_valid), 0);
        for (int c = 0; c < LAT; c++) begin
            @(negedge clk);
            chk(!q_valid, "R4 early output", addr_t'(q_valid), 0);
        end
        @(negedge clk);
        chk(q_valid == (exp_n > 0), "R4 first valid", addr_t'(q_valid), addr_t'(exp_n > 0));
        if (exp_n > 0) chk(q_addr == exp_list[0], "R4 first target", q_addr, exp_list[0]);
    endtask

    task automatic drain(input int pct, input int first);
        int got = first;
        int guard = 0;
        while (got < exp_n && guard < 600) begin
            @(negedge clk);
            guard++;
            if (q_valid && $urandom_range(99) < pct) begin
                chk(q_addr == exp_list[got], "R5 R9 chain order", q_addr, exp_list[got]);
                got++;
                q_ready = 1'b1;
            end else begin
                q_ready = 1'b0;
            end
        end
        @(negedge clk);
        q_ready = 1'b0;
        chk(got == exp_n, "R9 missing prediction", addr_t'(got), addr_t'(exp_n));
        if (!exp_open) begin
            bit extra = 1'b0;
            for (int c = 0; c < 4 * (LAT + 1); c++) begin
                @(negedge clk);
                if (q_valid) extra = 1'b1;
            end
            chk(!extra, "R6 output after miss", addr_t'(extra), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    addr_t a_a, a_b, a_c, a_d, a_dx, a_a2, a_z;
    addr_t p [6];

    initial begin
        void'($urandom(32'd4242));
        for (int e = 0; e < NENT; e++) begin
            m_vld[e] = 1'b0; m_tag[e] = '0; m_tgt[e] = '0;
        end
        a_a = mk(8'h10, 6'd1); a_b = mk(8'h10, 6'd2);
        a_c = mk(8'h10, 6'd3); a_d = mk(8'h10, 6'd4);
        a_dx = mk(8'h77, 6'd4); a_a2 = mk(8'h20, 6'd1); a_z = mk(8'h30, 6'd9);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!q_valid, "R1 q_valid in reset", addr_t'(q_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!q_valid, "R1 q_valid after reset", addr_t'(q_valid), 0);
        timed_start(mk(8'h10, 6'd1), 8);   // R1: empty table gives nothing
        drain(100, 0);

        // R3: program a short chain A->B->C->D, D misses
        redirect(1'b1, a_a, a_b);
        redirect(1'b1, a_b, a_c);
        redirect(1'b1, a_c, a_d);
        timed_start(a_a, 8);
        // R5: pop B at once; C is due LAT+1 edges after B was pushed
        q_ready = 1'b1;
        @(negedge clk);
        q_ready = 1'b0;
        for (int c = 0; c < LAT; c++) begin
            chk(!q_valid, "R5 link gap", addr_t'(q_valid), 0);
            @(negedge clk);
        end
        chk(q_valid && q_addr == a_c, "R5 second link", q_addr, a_c);
        drain(60, 1);

        // R6: tag mismatch at index of D
        redirect(1'b1, a_dx, a_a);
        timed_start(a_a, 8);
        drain(70, 0);
        timed_start(a_dx, 8);
        drain(70, 0);

        // R7: replace A's entry through a different tag
        redirect(1'b1, a_a2, a_c);
        timed_start(a_a, 8);
        drain(100, 0);
        timed_start(a_a2, 8);
        drain(100, 0);

        // R8: high address bits alias
        timed_start(a_a2 | 32'h8000_0000, 8);
        drain(100, 0);

        // R3: redirect without update writes nothing
        redirect(1'b0, a_z, a_b);
        timed_start(a_z, 8);
        drain(100, 0);

        // R9: loop of six blocks, queue fills while fetch stalls
        for (int i = 0; i < 6; i++) p[i] = mk(8'h40, 6'(20 + i));
        for (int i = 0; i < 6; i++) redirect(1'b1, p[i], p[(i + 1) % 6]);
        timed_start(p[0], 12);
        repeat (40) @(negedge clk);
        chk(q_valid && q_addr == p[1], "R10 head held while full", q_addr, p[1]);
        drain(100, 0);

        // R2: redirect while the queue is busy with the loop
        timed_start(a_a2, 8);
        drain(50, 0);

        // random tables, starts and fetch back-pressure
        for (int r = 0; r < 20; r++) begin
            for (int w = 0; w < 6; w++) begin
                addr_t s = mk($urandom_range(1) ? 8'h51 : 8'h50, 6'($urandom_range(40, 47)));
                addr_t t = mk($urandom_range(1) ? 8'h51 : 8'h50, 6'($urandom_range(40, 47)));
                redirect(1'b1, s, t);
            end
            timed_start(mk($urandom_range(1) ? 8'h51 : 8'h50, 6'($urandom_range(40, 47))), 12);
            drain($urandom_range(30, 100), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule